// File: doc/BRIEF.md
# Host Word-Access Memory Port

This block sits between an asynchronous host bus and a word-wide internal memory. The host presents a 12-bit word address, a 16-bit data word and three active-low strobes (chip enable, write enable, output enable). The strobes are brought into the controller clock domain through two-flop synchronizers. The block then performs one word read or one word write and reports completion on an active-low ready line.

The ready line is modelled as an open-drain output with an optional active pull-up. It comes out as a drive-enable and a drive-value pair. Ready is asserted by driving low. When the access ends, ready is driven high for a short, selectable time and then released. A mode input moves ready generation onto an external host bus clock. In that mode ready becomes a single low pulse, one host clock wide, aligned to that clock. The data bus is split into input, output and output-enable signals. The output enable follows chip enable and output enable directly, with no clock involved.

Top module: `hostword_port`

## Requirements
- R1: A word written to an address is returned by a later read of that address. Two addresses that differ only in bit 0 (even and odd word) hold independent 16-bit words.
- R2: During and right after reset, ready is released (`rdy_drv_en`=0) and the data bus is not driven while the strobes are high.
- R3: In asynchronous mode a write (chip enable and write enable low, output enable high) asserts ready (`rdy_drv_en`=1, `rdy_drv_val`=0) on the 3rd rising controller clock edge after the strobes fall. This lies within the allowed 1 to 4 cycles.
- R4: In asynchronous mode a read (chip enable and output enable low, write enable high) asserts ready on the 4th rising edge after the strobes fall. This lies within the allowed 1.5 to 8 cycles. `data_out` holds the stored word when ready asserts.
- R5: In asynchronous mode ready stays asserted while the access strobes stay low. Ready is driven high (`rdy_drv_en`=1, `rdy_drv_val`=1) from the 3rd rising edge after the strobes are released, for `rdy_rel_sel`+1 cycles, where `rdy_rel_sel` is a 2-bit code from 0 to 3. Ready is then released (`rdy_drv_en`=0). It never goes from asserted straight to released.
- R6: `data_oe` is 1 exactly while `ce_n` and `oe_n` are both 0. It follows them without waiting for a clock edge.
- R7: Chip enable low with both write enable and output enable low starts no access. Ready stays released and the memory is not changed.
- R8: A new access starts only after chip enable, write enable and output enable have all been seen high together in one synchronized cycle since the previous access.
- R9: With `host_sync_mode`=1, each access produces exactly one ready-low pulse, one `host_clk` cycle wide and changing on `host_clk` rising edges. Ready is then driven high for `rdy_rel_sel`+1 host clock cycles and then released. Releasing the strobes afterwards causes no further drive.
- R10: With `host_sync_mode`=0, ready timing does not depend on `host_clk`. Accesses complete with the R3 and R4 timing even when `host_clk` is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset, held across edges of both clocks |
| host_clk | input | 1 | Host bus clock, used only in host-clock ready mode |
| host_sync_mode | input | 1 | 1: ready is re-timed to `host_clk`; 0: ready is asynchronous |
| addr | input | 12 | Word address |
| data_in | input | 16 | Write data from the host |
| data_out | output | 16 | Read data to the host |
| data_oe | output | 1 | Data bus drive enable |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rdy_rel_sel | input | 2 | Length code for the ready-high drive after an access |
| rdy_drv_en | output | 1 | Ready pad drive enable (0 = released) |
| rdy_drv_val | output | 1 | Ready pad drive level |

## Verification
A corrupted access-state register shows at the ready pair within one controller cycle. The visible signs are a release that skips the high drive, a ready that never asserts, or a ready that stays asserted after the strobes return high. A stuck or missing re-arm flag shows as an access that is silently dropped or double-started. The bench sees this as a missing ready or as a read-back word that differs from the one stored. Errors in the host-clock path show as a pulse of the wrong width, counted in `host_clk` cycles, within a few host cycles of the access.

// File: rtl/hwp_pkg.sv
`timescale 1ns/1ps
// Shared types for the host word-access port.
// Assumes: ready is an open-drain pad with an active pull-up phase.
package hwp_pkg;

    // Controller-side access sequence states.
    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_READ = 2'd1,
        ACC_HOLD = 2'd2,
        ACC_REL  = 2'd3
    } acc_state_t;

    // Host-clock ready generator states.
    typedef enum logic [1:0] {
        HR_IDLE  = 2'd0,
        HR_PULSE = 2'd1,
        HR_REL   = 2'd2
    } hrdy_state_t;

    // Ready pad drive: en=0 released, en=1 drives val.
    typedef struct packed {
        logic en;
        logic val;
    } rdy_drive_t;

    localparam rdy_drive_t RDY_OFF  = '{en: 1'b0, val: 1'b1};
    localparam rdy_drive_t RDY_LOW  = '{en: 1'b1, val: 1'b0};
    localparam rdy_drive_t RDY_HIGH = '{en: 1'b1, val: 1'b1};

endpackage

// File: rtl/hwp_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a group of independent level signals.
// Assumes: STAGES >= 2; each bit is an independent quasi-static level.
module hwp_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift each input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {(STAGES*W){RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hwp_word_mem.sv
`timescale 1ns/1ps
// Word memory with one shared address: write port plus registered read.
// Assumes: the write and read enables are never high together.
module hwp_word_mem #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Store one word when a write is granted.
    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
    end

    // Capture the addressed word when a read is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[addr];
        end
    end
endmodule

// File: rtl/hwp_access_seq.sv
`timescale 1ns/1ps
// Access sequencer in the controller clock domain.
// Starts a read or a write from the synchronized strobes and holds ready
// low until the strobes are released. It then drives ready high for
// rel_code+1 cycles and releases it. It re-arms only after all strobes
// have been seen high together.
// Assumes: address and write data are stable while the strobes are low.
module hwp_access_seq
    import hwp_pkg::*;
#(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_ce_n,
    input  logic              s_we_n,
    input  logic              s_oe_n,
    input  logic [CODE_W-1:0] rel_code,
    output logic              mem_we,
    output logic              mem_re,
    output rdy_drive_t        rdy,
    output logic              done_tgl
);
    acc_state_t        state;
    logic              armed;
    logic              is_wr_q;
    logic [CODE_W-1:0] cnt;
    logic              all_high;
    logic              want_wr;
    logic              want_rd;
    logic              end_seen;

    // Decode the synchronized strobe pattern.
    always_comb begin
        all_high = s_ce_n & s_we_n & s_oe_n;
        want_wr  = ~s_ce_n & ~s_we_n &  s_oe_n;
        want_rd  = ~s_ce_n &  s_we_n & ~s_oe_n;
        end_seen = is_wr_q ? (s_ce_n | s_we_n) : (s_ce_n | s_oe_n);
        mem_we   = (state == ACC_IDLE) & armed & want_wr;
        mem_re   = (state == ACC_IDLE) & armed & want_rd;
    end

    // Track whether a fresh access may be accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (mem_we | mem_re) begin
            armed <= 1'b0;
        end else if (all_high) begin
            armed <= 1'b1;
        end
    end

    // Walk one access from start through hold and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ACC_IDLE;
            is_wr_q  <= 1'b0;
            cnt      <= '0;
            done_tgl <= 1'b0;
        end else begin
            unique case (state)
                ACC_IDLE: begin
                    if (mem_we) begin
                        state    <= ACC_HOLD;
                        is_wr_q  <= 1'b1;
                        done_tgl <= ~done_tgl;
                    end else if (mem_re) begin
                        state   <= ACC_READ;
                        is_wr_q <= 1'b0;
                    end
                end
                ACC_READ: begin
                    state    <= ACC_HOLD;
                    done_tgl <= ~done_tgl;
                end
                ACC_HOLD: begin
                    if (end_seen) begin
                        state <= ACC_REL;
                        cnt   <= rel_code;
                    end
                end
                ACC_REL: begin
                    if (cnt == '0) begin
                        state <= ACC_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ACC_IDLE;
            endcase
        end
    end

    // Map the state to the ready pad drive.
    always_comb begin
        unique case (state)
            ACC_HOLD: rdy = RDY_LOW;
            ACC_REL:  rdy = RDY_HIGH;
            default:  rdy = RDY_OFF;
        endcase
    end
endmodule

// File: rtl/hwp_host_ready.sv
`timescale 1ns/1ps
// Ready generator in the host clock domain.
// Turns each completion toggle into one host-clock-wide low pulse,
// followed by rel_code+1 host cycles of driven high, then release.
// Assumes: accesses are spaced so that the previous release has ended
// before the next completion toggle arrives.
module hwp_host_ready
    import hwp_pkg::*;
#(
    parameter int CODE_W = 2
) (
    input  logic              host_clk,
    input  logic              rst_n,
    input  logic              done_tgl,
    input  logic [CODE_W-1:0] rel_code,
    output rdy_drive_t        rdy
);
    hrdy_state_t       state;
    logic              tgl_s;
    logic              tgl_prev;
    logic [CODE_W-1:0] cnt;
    logic              evt;

    hwp_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_tgl_sync (
        .clk   (host_clk),
        .rst_n (rst_n),
        .d     (done_tgl),
        .q     (tgl_s)
    );

    assign evt = tgl_s ^ tgl_prev;

    // Remember the last synchronized toggle level.
    always_ff @(posedge host_clk) begin
        if (!rst_n) begin
            tgl_prev <= 1'b0;
        end else begin
            tgl_prev <= tgl_s;
        end
    end

    // Sequence pulse, high drive and release on host clock edges.
    always_ff @(posedge host_clk) begin
        if (!rst_n) begin
            state <= HR_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                HR_IDLE: begin
                    if (evt) begin
                        state <= HR_PULSE;
                    end
                end
                HR_PULSE: begin
                    state <= HR_REL;
                    cnt   <= rel_code;
                end
                HR_REL: begin
                    if (cnt == '0) begin
                        state <= HR_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= HR_IDLE;
            endcase
        end
    end

    // Map the state to the ready pad drive.
    always_comb begin
        unique case (state)
            HR_PULSE: rdy = RDY_LOW;
            HR_REL:   rdy = RDY_HIGH;
            default:  rdy = RDY_OFF;
        endcase
    end
endmodule

// File: rtl/hostword_port.sv
`timescale 1ns/1ps
// Host word-access port in front of a word memory.
// Synchronizes the host strobes, sequences one word read or write per
// access and reports completion on an open-drain style ready output.
// Ready is produced either asynchronously or aligned to host_clk.
// Assumes: host_sync_mode and rdy_rel_sel change only while idle;
// rst_n is held across edges of both clocks.
module hostword_port
    import hwp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_clk,
    input  logic              host_sync_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [CODE_W-1:0] rdy_rel_sel,
    output logic              rdy_drv_en,
    output logic              rdy_drv_val
);
    localparam int NSTROBE = 3;

    logic [NSTROBE-1:0] strb_s;
    logic               mem_we;
    logic               mem_re;
    logic               done_tgl;
    rdy_drive_t         acc_rdy;
    rdy_drive_t         host_rdy;

    hwp_sync #(.W(NSTROBE), .STAGES(2), .RST_VAL(1'b1)) u_strobe_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_n, we_n, oe_n}),
        .q     (strb_s)
    );

    hwp_access_seq #(.CODE_W(CODE_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_ce_n   (strb_s[2]),
        .s_we_n   (strb_s[1]),
        .s_oe_n   (strb_s[0]),
        .rel_code (rdy_rel_sel),
        .mem_we   (mem_we),
        .mem_re   (mem_re),
        .rdy      (acc_rdy),
        .done_tgl (done_tgl)
    );

    hwp_word_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (addr),
        .wdata (data_in),
        .rdata (data_out)
    );

    hwp_host_ready #(.CODE_W(CODE_W)) u_host_rdy (
        .host_clk (host_clk),
        .rst_n    (rst_n),
        .done_tgl (done_tgl),
        .rel_code (rdy_rel_sel),
        .rdy      (host_rdy)
    );

    // Drive the data bus only while the host reads.
    assign data_oe = ~ce_n & ~oe_n;

    // Select the ready source for the chosen mode.
    always_comb begin
        if (host_sync_mode) begin
            rdy_drv_en  = host_rdy.en;
            rdy_drv_val = host_rdy.val;
        end else begin
            rdy_drv_en  = acc_rdy.en;
            rdy_drv_val = acc_rdy.val;
        end
    end
endmodule

// File: rtl/hwp_checker.sv
`timescale 1ns/1ps
// Protocol checker for the host word-access port, bound to the top.
// Assumes: the mode input changes only while the port is idle.
module hwp_checker (
    input logic clk,
    input logic host_clk,
    input logic rst_n,
    input logic host_sync_mode,
    input logic rdy_drv_en,
    input logic rdy_drv_val,
    input logic mem_we,
    input logic mem_re
);
    // R5: release to high impedance only after a driven-high phase.
    assert_release_after_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_sync_mode && $past(!host_sync_mode) && $past(rdy_drv_en) && !rdy_drv_en)
        |-> $past(rdy_drv_val));

    // R5: an asserted ready is always followed by a driven-high phase.
    assert_low_then_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_sync_mode && $past(!host_sync_mode) && $past(rdy_drv_en && !rdy_drv_val)
         && !(rdy_drv_en && !rdy_drv_val))
        |-> (rdy_drv_en && rdy_drv_val));

    // R3: a granted write shows ready low on the next cycle.
    assert_write_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_sync_mode && mem_we) |=> (rdy_drv_en && !rdy_drv_val));

    // R4: a granted read shows ready low two cycles later.
    assert_read_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_sync_mode && $past(!host_sync_mode, 2) && $past(mem_re, 2))
        |-> (rdy_drv_en && !rdy_drv_val));

    // R8: an access is only granted while ready is released.
    assert_start_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_sync_mode && (mem_we || mem_re)) |-> !rdy_drv_en);

    // R9: the host-clock ready pulse lasts one host cycle.
    assert_host_pulse_R9: assert property (@(posedge host_clk) disable iff (!rst_n)
        (host_sync_mode && rdy_drv_en && !rdy_drv_val)
        |=> !(rdy_drv_en && !rdy_drv_val));
endmodule

bind hostword_port hwp_checker chk_i (
    .clk            (clk),
    .host_clk       (host_clk),
    .rst_n          (rst_n),
    .host_sync_mode (host_sync_mode),
    .rdy_drv_en     (rdy_drv_en),
    .rdy_drv_val    (rdy_drv_val),
    .mem_we         (mem_we),
    .mem_re         (mem_re)
);

// File: tb/hostword_port_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: table-driven accesses, then directed corner cases.
module hostword_port_tb_top;
    logic        clk = 1'b0;
    logic        host_clk = 1'b0;
    logic        hclk_run = 1'b1;
    logic        rst_n = 1'b0;
    logic        host_sync_mode = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] data_in = '0;
    logic [15:0] data_out;
    logic        data_oe;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [1:0]  rdy_rel_sel = 2'd0;
    logic        rdy_drv_en;
    logic        rdy_drv_val;

    int total = 0;
    int bad = 0;

    // {wr, addr[11:0], data[15:0], release code[1:0]}
    localparam int NVEC = 10;
    localparam logic [30:0] VECS [NVEC] = '{
        {1'b1, 12'h0A4, 16'h1234, 2'd0},
        {1'b1, 12'h0A5, 16'h5678, 2'd1},
        {1'b1, 12'hFFF, 16'hBEEF, 2'd3},
        {1'b1, 12'h000, 16'h0001, 2'd2},
        {1'b0, 12'h0A4, 16'h1234, 2'd2},
        {1'b0, 12'h0A5, 16'h5678, 2'd0},
        {1'b0, 12'hFFF, 16'hBEEF, 2'd1},
        {1'b0, 12'h000, 16'h0001, 2'd3},
        {1'b1, 12'h0A4, 16'hCAFE, 2'd1},
        {1'b0, 12'h0A4, 16'hCAFE, 2'd3}
    };

    hostword_port dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_clk       (host_clk),
        .host_sync_mode (host_sync_mode),
        .addr           (addr),
        .data_in        (data_in),
        .data_out       (data_out),
        .data_oe        (data_oe),
        .ce_n           (ce_n),
        .we_n           (we_n),
        .oe_n           (oe_n),
        .rdy_rel_sel    (rdy_rel_sel),
        .rdy_drv_en     (rdy_drv_en),
        .rdy_drv_val    (rdy_drv_val)
    );

    initial forever #2 clk = ~clk;
    initial forever begin
        #5;
        if (hclk_run) host_clk = ~host_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // One asynchronous-mode access with timing, data and release checks.
    task automatic run_access(input bit wr, input logic [11:0] a,
                              input logic [15:0] d, input logic [1:0] code);
        int lat;
        int hi;
        bit seen;
        @(negedge clk);
        rdy_rel_sel = code;
        addr = a;
        data_in = wr ? d : 16'h0;
        ce_n = 1'b0;
        if (wr) we_n = 1'b0; else oe_n = 1'b0;
        #1;
        chk(data_oe == !wr, "R6 bus drive on strobe", int'(data_oe), int'(!wr));
        lat = 0;
        seen = 1'b0;
        for (int k = 0; k < 12 && !seen; k++) begin
            @(negedge clk);
            lat++;
            if (rdy_drv_en && !rdy_drv_val) seen = 1'b1;
        end
        if (wr) chk(lat == 3, "R3 write ready latency", lat, 3);
        else    chk(lat == 4, "R4 read ready latency", lat, 4);
        if (!wr) chk(data_out == d, "R1 R4 read data", int'(data_out), int'(d));
        repeat (5) @(negedge clk);
        chk(rdy_drv_en && !rdy_drv_val, "R5 ready held while strobes low",
            int'({rdy_drv_en, rdy_drv_val}), 2);
        ce_n = 1'b1;
        we_n = 1'b1;
        oe_n = 1'b1;
        #1;
        chk(data_oe == 1'b0, "R6 bus released", int'(data_oe), 0);
        lat = 0;
        seen = 1'b0;
        for (int k = 0; k < 12 && !seen; k++) begin
            @(negedge clk);
            lat++;
            if (rdy_drv_en && rdy_drv_val) seen = 1'b1;
        end
        chk(lat == 3, "R5 high drive start", lat, 3);
        hi = 0;
        while (rdy_drv_en && rdy_drv_val && hi < 10) begin
            hi++;
            @(negedge clk);
        end
        chk(hi == int'(code) + 1, "R5 high drive length", hi, int'(code) + 1);
        chk(rdy_drv_en == 1'b0, "R5 released after high", int'(rdy_drv_en), 0);
        repeat (2) @(negedge clk);
    endtask

    // One host-clock-mode access; pulse measured in host clock cycles.
    task automatic host_access(input bit wr, input logic [11:0] a,
                               input logic [15:0] d, input logic [1:0] code);
        int p;
        int hi;
        int extra;
        bit seen;
        @(negedge clk);
        rdy_rel_sel = code;
        addr = a;
        data_in = wr ? d : 16'h0;
        ce_n = 1'b0;
        if (wr) we_n = 1'b0; else oe_n = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 40 && !seen; k++) begin
            @(negedge host_clk);
            if (rdy_drv_en && !rdy_drv_val) seen = 1'b1;
        end
        chk(seen, "R9 host pulse seen", int'(seen), 1);
        if (!wr) chk(data_out == d, "R9 R1 host-mode read data", int'(data_out), int'(d));
        p = 0;
        while (rdy_drv_en && !rdy_drv_val && p < 10) begin
            p++;
            @(negedge host_clk);
        end
        chk(p == 1, "R9 pulse width host cycles", p, 1);
        hi = 0;
        while (rdy_drv_en && rdy_drv_val && hi < 10) begin
            hi++;
            @(negedge host_clk);
        end
        chk(hi == int'(code) + 1, "R9 high drive host cycles", hi, int'(code) + 1);
        chk(rdy_drv_en == 1'b0, "R9 released", int'(rdy_drv_en), 0);
        @(negedge clk);
        ce_n = 1'b1;
        we_n = 1'b1;
        oe_n = 1'b1;
        extra = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (rdy_drv_en) extra++;
        end
        chk(extra == 0, "R9 no drive after strobe release", extra, 0);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog all-requirements act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cnt;
        repeat (4) @(negedge clk);
        // R2: reset state.
        chk(rdy_drv_en == 1'b0, "R2 ready released in reset", int'(rdy_drv_en), 0);
        chk(data_oe == 1'b0, "R2 bus idle in reset", int'(data_oe), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(rdy_drv_en == 1'b0, "R2 ready released after reset", int'(rdy_drv_en), 0);

        // Table walk: R1, R3, R4, R5, R6.
        for (int i = 0; i < NVEC; i++) begin
            run_access(VECS[i][30], VECS[i][29:18], VECS[i][17:2], VECS[i][1:0]);
        end

        // R7: both write and output enable low starts nothing.
        @(negedge clk);
        addr = 12'h0A5;
        data_in = 16'hDEAD;
        ce_n = 1'b0;
        we_n = 1'b0;
        oe_n = 1'b0;
        cnt = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (rdy_drv_en) cnt++;
        end
        chk(cnt == 0, "R7 no ready for ambiguous strobes", cnt, 0);
        ce_n = 1'b1;
        we_n = 1'b1;
        oe_n = 1'b1;
        repeat (6) @(negedge clk);
        run_access(1'b0, 12'h0A5, 16'h5678, 2'd0); // R7 memory unchanged

        // R8: no new access while chip enable never went high.
        @(negedge clk);
        rdy_rel_sel = 2'd0;
        addr = 12'h010;
        data_in = 16'h1111;
        ce_n = 1'b0;
        we_n = 1'b0;
        cnt = 0;
        for (int k = 0; k < 12 && !(rdy_drv_en && !rdy_drv_val); k++) @(negedge clk);
        chk(rdy_drv_en && !rdy_drv_val, "R8 first write ready",
            int'({rdy_drv_en, rdy_drv_val}), 2);
        we_n = 1'b1;
        for (int k = 0; k < 20 && rdy_drv_en; k++) @(negedge clk);
        repeat (2) @(negedge clk);
        data_in = 16'h2222;
        we_n = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (rdy_drv_en) cnt++;
        end
        chk(cnt == 0, "R8 second write not accepted", cnt, 0);
        ce_n = 1'b1;
        we_n = 1'b1;
        repeat (6) @(negedge clk);
        run_access(1'b0, 12'h010, 16'h1111, 2'd1); // R8 memory keeps first word

        // R10: asynchronous ready with the host clock stopped.
        hclk_run = 1'b0;
        run_access(1'b1, 12'h020, 16'h3333, 2'd1);
        run_access(1'b0, 12'h020, 16'h3333, 2'd2);
        hclk_run = 1'b1;
        repeat (30) @(negedge clk);

        // R9: host-clock aligned ready.
        host_sync_mode = 1'b1;
        host_access(1'b1, 12'h030, 16'hA5A5, 2'd2);
        repeat (10) @(negedge clk);
        host_access(1'b0, 12'h030, 16'hA5A5, 2'd0);
        repeat (30) @(negedge clk);
        host_sync_mode = 1'b0;
        run_access(1'b0, 12'h030, 16'hA5A5, 2'd3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule